// File: doc/BRIEF.md
# IPv4 and TCP/UDP Header Exception Classifier

This block watches an IPv4 packet one byte per cycle, starting at the first byte of the IP header. A start flag marks the first byte, a valid flag qualifies each byte, and an end flag marks the last byte. While the bytes pass, the block collects the header fields it needs. It also runs three ones-complement word sums: one over the IP header, one over the source and destination addresses, and one over the TCP or UDP segment.

When the last byte has been accepted, the block produces a done pulse together with two codes. The first is a single prioritized IP exception code. The second is a single prioritized transport-layer error code. The packet is not altered or stored. The codes are meant for a downstream stage that decides what to do with the packet.

Top module: `ip_l4_exc_classifier`

## Requirements
- R1: While reset is held and after it is released, `done`, `ip_code` and `l4_code` are all 0.
- R2: A byte is accepted when `in_valid` is high and either `in_sop` is high or a packet is open. A packet opens with an accepted byte that has `in_sop` set. It closes with an accepted byte that has `in_eop` set. `done` pulses for exactly one cycle in the cycle after the closing byte. Both codes appear with that pulse and hold until the next pulse. Valid bytes outside an open packet are ignored and raise no pulse.
- R3: `ip_code` is 1 (not IPv4) when the upper nibble of byte 0 is not 4 or its lower nibble (header length in 32-bit words) is below 5.
- R4: `ip_code` is 2 when the whole header (header length × 4 bytes) arrived and the end-around-carry sum of its 16-bit big-endian words is not 0xFFFF.
- R5: `ip_code` is 3 when fewer bytes than the header length arrived, or the total length field (bytes 2–3) is below the header length. It is 4 when fewer bytes than the total length arrived. Bytes beyond the total length are ignored.
- R6: `ip_code` is 5 when the TTL (byte 8) is zero and 6 when the header length exceeds 5 words. The IP checks are ranked in numeric order from 1 up, and the lowest matching code is reported.
- R7: Transport checks run only when the protocol byte (byte 9) is 6 (TCP) or 17 (UDP) and `ip_code` is 0, 5 or 6. Otherwise `l4_code` is 0.
- R8: `l4_code` is 1 when the segment length (total length minus header length) is below 8 for UDP or below 20 for TCP. For TCP it is also 1 when the data offset (upper nibble of segment byte 12) is below 5 or, multiplied by 4, exceeds the segment length.
- R9: `l4_code` is 2 when the end-around-carry sum of the following words is not 0xFFFF: both addresses, the protocol byte, the segment length, and the segment itself with an odd final byte padded by a zero low byte. A UDP checksum field (segment bytes 6–7) of zero skips this check.
- R10: `l4_code` is 3 for UDP when the length field (segment bytes 4–5) differs from the segment length.
- R11: `l4_code` is 4 when the source port (segment bytes 0–1) or the destination port (bytes 2–3) is zero.
- R12: For TCP, the flag byte (segment byte 13) is decoded from its six low bits: FIN = bit 0, SYN = 1, RST = 2, URG = 5, with bits 6 and 7 ignored. `l4_code` is 8 when only FIN is set and 9 when none of the six is set. It is 10 for FIN with RST, 11 for SYN with URG, 12 for SYN with RST, and 13 for SYN with FIN. For codes 10 to 13 other flags may also be set, and these flag tests are ranked from 8 up to 13.
- R13: Transport errors are ranked as follows: malformed (1) first, then checksum (2), then length (3), then port (4), then the flag codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | First byte of a packet (IP header byte 0) |
| in_eop | input | 1 | Last byte of a packet |
| in_byte | input | 8 | Packet byte |
| done | output | 1 | One-cycle pulse after the last byte |
| ip_code | output | 3 | IP exception code |
| l4_code | output | 4 | Transport error code |

## Verification
The only results of this block are `done` and the two codes. They are due in the first cycle after the clock edge that accepts the byte carrying `in_eop`. The bench drives each byte on a falling edge and releases `in_valid` on the falling edge after the last byte. It reads `done` and both codes at that same falling edge, and checks again one falling edge later that `done` has dropped. For stray bytes outside a packet, the bench reads the outputs at each falling edge after every such byte, confirming that no pulse appears and that the previous codes stay in place.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 16;
    localparam int IP_MIN_IHL  = 5;
    localparam int TCP_MIN_LEN = 20;
    localparam int UDP_HDR_LEN = 8;

    localparam logic [BYTE_W-1:0] PROTO_TCP = 8'd6;
    localparam logic [BYTE_W-1:0] PROTO_UDP = 8'd17;
    localparam logic [WORD_W-1:0] SUM_GOOD  = 16'hFFFF;

    typedef enum logic [2:0] {
        IPX_OK        = 3'd0,
        IPX_NOT_V4    = 3'd1,
        IPX_HDR_SUM   = 3'd2,
        IPX_SHORT_HDR = 3'd3,
        IPX_SHORT_PKT = 3'd4,
        IPX_TTL_ZERO  = 3'd5,
        IPX_OPTIONS   = 3'd6
    } ip_exc_e;

    typedef enum logic [3:0] {
        L4X_OK       = 4'd0,
        L4X_SHORT    = 4'd1,
        L4X_SUM      = 4'd2,
        L4X_LEN      = 4'd3,
        L4X_PORT     = 4'd4,
        L4X_FIN_ONLY = 4'd8,
        L4X_NO_FLAGS = 4'd9,
        L4X_FIN_RST  = 4'd10,
        L4X_SYN_URG  = 4'd11,
        L4X_SYN_RST  = 4'd12,
        L4X_SYN_FIN  = 4'd13
    } l4_err_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ver_ihl;
        logic [WORD_W-1:0] tot_len;
        logic [BYTE_W-1:0] ttl;
        logic [BYTE_W-1:0] proto;
    } l3_fields_t;

    typedef struct packed {
        logic [WORD_W-1:0] sport;
        logic [WORD_W-1:0] dport;
        logic [WORD_W-1:0] ulen;
        logic [WORD_W-1:0] usum;
        logic [3:0]        doff;
        logic [BYTE_W-1:0] flags;
    } l4_fields_t;

    // Ones-complement add with end-around carry; never overflows 16 bits.
    function automatic logic [WORD_W-1:0] oc_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
        logic [WORD_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
    endfunction

    // Flag byte decode: bit0 FIN, bit1 SYN, bit2 RST, bit5 URG; bits 7:6 ignored.
    function automatic l4_err_e tcp_flag_code(input logic [BYTE_W-1:0] fl);
        logic [5:0] f;
        f = fl[5:0];
        if (f == 6'b000001)      return L4X_FIN_ONLY;
        else if (f == 6'b000000) return L4X_NO_FLAGS;
        else if (f[0] && f[2])   return L4X_FIN_RST;
        else if (f[1] && f[5])   return L4X_SYN_URG;
        else if (f[1] && f[2])   return L4X_SYN_RST;
        else if (f[1] && f[0])   return L4X_SYN_FIN;
        else                     return L4X_OK;
    endfunction

endpackage

// File: rtl/ipx_csum_acc.sv
module ipx_csum_acc
    import ipx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              restart,
    input  logic              take,
    input  logic              low_half,
    input  logic              pad,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [WORD_W-1:0] fin
);

    logic [WORD_W-1:0] sum_q, base_sum, sum_nx;
    logic [BYTE_W-1:0] hi_q, base_hi, hi_nx;

    always_comb begin
        base_sum = restart ? '0 : sum_q;
        base_hi  = restart ? '0 : hi_q;
        sum_nx   = base_sum;
        hi_nx    = base_hi;
        if (take) begin
            if (low_half) sum_nx = oc_add(base_sum, {base_hi, in_byte});
            else          hi_nx  = in_byte;
        end
        fin = pad ? oc_add(sum_nx, {hi_nx, {BYTE_W{1'b0}}}) : sum_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            hi_q  <= '0;
        end else if (step) begin
            sum_q <= sum_nx;
            hi_q  <= hi_nx;
        end
    end

    // R9: an end-around-carry sum that is nonzero can never return to zero.
    p_sum_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && sum_q != '0) |=> (sum_q != '0));

endmodule

// File: rtl/ipx_l3_capture.sv
module ipx_l3_capture
    import ipx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              accept,
    output logic [CNT_W-1:0]  cur_idx,
    output logic [CNT_W:0]    cnt_nx,
    output l3_fields_t        l3_nx
);

    logic             in_pkt_q;
    logic [CNT_W-1:0] idx_q;
    l3_fields_t       l3_q, base;

    assign accept  = in_valid && (in_sop || in_pkt_q);
    assign cur_idx = in_sop ? '0 : idx_q;
    assign cnt_nx  = {1'b0, cur_idx} + (CNT_W+1)'(1);

    always_comb begin
        base  = in_sop ? '0 : l3_q;
        l3_nx = base;
        if (accept) begin
            if (cur_idx == CNT_W'(0)) l3_nx.ver_ihl       = in_byte;
            if (cur_idx == CNT_W'(2)) l3_nx.tot_len[15:8] = in_byte;
            if (cur_idx == CNT_W'(3)) l3_nx.tot_len[7:0]  = in_byte;
            if (cur_idx == CNT_W'(8)) l3_nx.ttl           = in_byte;
            if (cur_idx == CNT_W'(9)) l3_nx.proto         = in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt_q <= 1'b0;
            idx_q    <= '0;
            l3_q     <= '0;
        end else if (accept) begin
            in_pkt_q <= !in_eop;
            idx_q    <= (&cur_idx) ? cur_idx : cur_idx + CNT_W'(1);
            l3_q     <= l3_nx;
        end
    end

    // R2: a packet start restarts the byte position.
    p_idx_after_sop_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && in_sop && !in_eop) |=> (idx_q == CNT_W'(1)));

    // R2: stray bytes outside an open packet leave the position alone.
    p_stray_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sop && !in_pkt_q) |=> $stable(idx_q));

endmodule

// File: rtl/ipx_l4_capture.sv
module ipx_l4_capture
    import ipx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              restart,
    input  logic              take,
    input  logic [CNT_W-1:0]  rel,
    input  logic [BYTE_W-1:0] in_byte,
    output l4_fields_t        l4_nx
);

    l4_fields_t l4_q, base;

    always_comb begin
        base  = restart ? '0 : l4_q;
        l4_nx = base;
        if (take) begin
            if (rel == CNT_W'(0))  l4_nx.sport[15:8] = in_byte;
            if (rel == CNT_W'(1))  l4_nx.sport[7:0]  = in_byte;
            if (rel == CNT_W'(2))  l4_nx.dport[15:8] = in_byte;
            if (rel == CNT_W'(3))  l4_nx.dport[7:0]  = in_byte;
            if (rel == CNT_W'(4))  l4_nx.ulen[15:8]  = in_byte;
            if (rel == CNT_W'(5))  l4_nx.ulen[7:0]   = in_byte;
            if (rel == CNT_W'(6))  l4_nx.usum[15:8]  = in_byte;
            if (rel == CNT_W'(7))  l4_nx.usum[7:0]   = in_byte;
            if (rel == CNT_W'(12)) l4_nx.doff        = in_byte[7:4];
            if (rel == CNT_W'(13)) l4_nx.flags       = in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       l4_q <= '0;
        else if (step) l4_q <= l4_nx;
    end

endmodule

// File: rtl/ip_l4_exc_classifier.sv
module ip_l4_exc_classifier
    import ipx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              done,
    output logic [2:0]        ip_code,
    output logic [3:0]        l4_code
);

    localparam int N_ACC    = 3;
    localparam int ACC_IP   = 0;
    localparam int ACC_ADDR = 1;
    localparam int ACC_L4   = 2;
    localparam int ADDR_LO  = 12;
    localparam int ADDR_HI  = 20;

    logic             accept;
    logic [CNT_W-1:0] cur_idx, rel;
    logic [CNT_W:0]   cnt_nx;
    l3_fields_t       l3_nx;
    l4_fields_t       l4_nx;

    int unsigned idx_i, cnt_i, hlen_i, tlen_i;
    logic [3:0]        ver, ihl;
    logic [WORD_W-1:0] l4len;
    logic              in_l4;

    logic [N_ACC-1:0]  acc_take, acc_pad;
    logic [WORD_W-1:0] acc_fin [N_ACC];

    ip_exc_e ip_c, ip_q;
    l4_err_e l4_c, l4_q;
    logic    done_q;

    ipx_l3_capture #(.CNT_W(CNT_W)) u_l3 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .accept(accept),
        .cur_idx(cur_idx), .cnt_nx(cnt_nx), .l3_nx(l3_nx)
    );

    assign ver    = l3_nx.ver_ihl[7:4];
    assign ihl    = l3_nx.ver_ihl[3:0];
    assign idx_i  = 32'(cur_idx);
    assign cnt_i  = 32'(cnt_nx);
    assign hlen_i = 32'({ihl, 2'b00});
    assign tlen_i = 32'(l3_nx.tot_len);
    assign l4len  = l3_nx.tot_len - WORD_W'(hlen_i);
    assign in_l4  = (idx_i >= hlen_i) && (idx_i < tlen_i);
    assign rel    = cur_idx - CNT_W'(hlen_i);

    ipx_l4_capture #(.CNT_W(CNT_W)) u_l4 (
        .clk(clk), .rst(rst), .step(accept), .restart(in_sop),
        .take(accept && in_l4), .rel(rel), .in_byte(in_byte), .l4_nx(l4_nx)
    );

    always_comb begin
        acc_take[ACC_IP]   = accept && (idx_i < hlen_i);
        acc_take[ACC_ADDR] = accept && (idx_i >= ADDR_LO) && (idx_i < ADDR_HI);
        acc_take[ACC_L4]   = accept && in_l4;
        acc_pad[ACC_IP]    = 1'b0;
        acc_pad[ACC_ADDR]  = 1'b0;
        acc_pad[ACC_L4]    = l4len[0];
    end

    // Header length is a multiple of four, so byte parity is shared by all sums.
    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        ipx_csum_acc u_acc (
            .clk(clk), .rst(rst), .step(accept), .restart(in_sop),
            .take(acc_take[g]), .low_half(cur_idx[0]), .pad(acc_pad[g]),
            .in_byte(in_byte), .fin(acc_fin[g])
        );
    end

    // IP exception ranking (R3..R6)
    always_comb begin
        if (ver != 4'd4 || ihl < 4'(IP_MIN_IHL))
            ip_c = IPX_NOT_V4;
        else if (cnt_i >= hlen_i && acc_fin[ACC_IP] != SUM_GOOD)
            ip_c = IPX_HDR_SUM;
        else if (cnt_i < hlen_i || tlen_i < hlen_i)
            ip_c = IPX_SHORT_HDR;
        else if (cnt_i < tlen_i)
            ip_c = IPX_SHORT_PKT;
        else if (l3_nx.ttl == '0)
            ip_c = IPX_TTL_ZERO;
        else if (ihl > 4'(IP_MIN_IHL))
            ip_c = IPX_OPTIONS;
        else
            ip_c = IPX_OK;
    end

    // Transport error ranking (R7..R13)
    logic              is_tcp, is_udp, l4_run;
    logic              l4_short, l4_sum_bad, l4_len_bad, l4_port_bad;
    logic [WORD_W-1:0] l4_total;

    always_comb begin
        is_tcp   = (l3_nx.proto == PROTO_TCP);
        is_udp   = (l3_nx.proto == PROTO_UDP);
        l4_run   = (is_tcp || is_udp) &&
                   (ip_c == IPX_OK || ip_c == IPX_TTL_ZERO || ip_c == IPX_OPTIONS);
        l4_total = oc_add(oc_add(oc_add(acc_fin[ACC_L4], acc_fin[ACC_ADDR]),
                                 {{BYTE_W{1'b0}}, l3_nx.proto}), l4len);
        if (is_tcp)
            l4_short = (l4len < WORD_W'(TCP_MIN_LEN)) ||
                       (l4_nx.doff < 4'(IP_MIN_IHL)) ||
                       (WORD_W'({l4_nx.doff, 2'b00}) > l4len);
        else
            l4_short = (l4len < WORD_W'(UDP_HDR_LEN));
        l4_sum_bad  = !(is_udp && l4_nx.usum == '0) && (l4_total != SUM_GOOD);
        l4_len_bad  = is_udp && (l4_nx.ulen != l4len);
        l4_port_bad = (l4_nx.sport == '0) || (l4_nx.dport == '0);

        l4_c = L4X_OK;
        if (l4_run) begin
            if (l4_short)         l4_c = L4X_SHORT;
            else if (l4_sum_bad)  l4_c = L4X_SUM;
            else if (l4_len_bad)  l4_c = L4X_LEN;
            else if (l4_port_bad) l4_c = L4X_PORT;
            else if (is_tcp)      l4_c = tcp_flag_code(l4_nx.flags);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ip_q   <= IPX_OK;
            l4_q   <= L4X_OK;
        end else begin
            done_q <= accept && in_eop;
            if (accept && in_eop) begin
                ip_q <= ip_c;
                l4_q <= l4_c;
            end
        end
    end

    assign done    = done_q;
    assign ip_code = ip_q;
    assign l4_code = l4_q;

    // R2: a pulse only ever follows a byte marked as last.
    p_done_after_eop_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_eop));

    // R2: codes move only together with the pulse.
    p_codes_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(ip_code) && $stable(l4_code)));

    // R7: serious IP faults silence the transport result.
    p_l4_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (done && ip_code >= 3'd1 && ip_code <= 3'd4) |-> (l4_code == 4'd0));

    // R12: only defined transport codes are ever reported.
    p_l4_legal_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (l4_code <= 4'd4 || (l4_code >= 4'd8 && l4_code <= 4'd13)));

endmodule

// File: tb/tb_ip_l4_exc_classifier.sv
module tb_ip_l4_exc_classifier;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       done;
    logic [2:0] ip_code;
    logic [3:0] l4_code;

    always #5 clk = ~clk;

    ip_l4_exc_classifier dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .done(done),
        .ip_code(ip_code), .l4_code(l4_code)
    );

    int n_checks = 0;
    int n_err    = 0;

    logic [7:0] pkt [0:255];
    int hl, tl, prt;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned wsum(input int a, input int b);
        int unsigned s = 0;
        for (int i = a; i < b; i += 2)
            s += (i + 1 < b) ? (pkt[i] * 256 + pkt[i+1]) : (pkt[i] * 256);
        return s;
    endfunction

    function automatic int unsigned fold(input int unsigned v);
        int unsigned s = v;
        while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
        return s;
    endfunction

    task automatic put16(input int at, input int v);
        pkt[at]   = 8'((v >> 8) & 255);
        pkt[at+1] = 8'(v & 255);
    endtask

    task automatic fix_ip();
        int unsigned c;
        put16(10, 0);
        c = ~fold(wsum(0, hl)) & 32'hFFFF;
        put16(10, int'(c));
    endtask

    task automatic fix_l4();
        int cs;
        int unsigned c;
        if (prt == 6) cs = hl + 16;
        else if (prt == 17) cs = hl + 6;
        else return;
        if (cs + 2 > tl) return;
        put16(cs, 0);
        c = ~fold(wsum(hl, tl) + wsum(12, 20) + prt + (tl - hl)) & 32'hFFFF;
        if (prt == 17 && c == 0) c = 32'hFFFF;
        put16(cs, int'(c));
    endtask

    task automatic mk_pkt(input int ihl, input int proto, input int l4len, input int ttl);
        for (int i = 0; i < 256; i++) pkt[i] = 8'((i * 7 + 3) & 255);
        hl = ihl * 4; tl = hl + l4len; prt = proto;
        pkt[0] = {4'd4, 4'(ihl)};
        pkt[1] = 8'h00;
        put16(2, tl);
        pkt[8] = 8'(ttl);
        pkt[9] = 8'(proto);
        pkt[12] = 8'd10;  pkt[13] = 8'd1;   pkt[14] = 8'd2; pkt[15] = 8'd3;
        pkt[16] = 8'd192; pkt[17] = 8'd168; pkt[18] = 8'd7; pkt[19] = 8'd9;
        if (proto == 6) begin
            put16(hl, 16'h1234);
            put16(hl + 2, 16'h0050);
            pkt[hl+12] = 8'h50;
            pkt[hl+13] = 8'h10;
        end else if (proto == 17) begin
            put16(hl, 16'h1234);
            put16(hl + 2, 16'h0035);
            put16(hl + 4, l4len);
        end
        fix_ip();
        fix_l4();
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == n - 1);
            in_byte  = pkt[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic run(input string req, input int n, input int exp_ip, input int exp_l4);
        send(n);
        chk({req, " done"}, int'(done), 1);
        chk({req, " ip_code"}, int'(ip_code), exp_ip);
        chk({req, " l4_code"}, int'(l4_code), exp_l4);
    endtask

    function automatic int flag_exp(input int f);
        int g = f & 63;
        if (g == 1) return 8;
        if (g == 0) return 9;
        if ((g & 5) == 5) return 10;
        if ((g & 34) == 34) return 11;
        if ((g & 6) == 6) return 12;
        if ((g & 3) == 3) return 13;
        return 0;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 done", int'(done), 0);
        chk("R1 ip_code", int'(ip_code), 0);
        chk("R1 l4_code", int'(l4_code), 0);

        // R2 good TCP, then pulse lasts one cycle
        mk_pkt(5, 6, 28, 64);
        run("R2 good tcp", tl, 0, 0);
        @(negedge clk);
        chk("R2 single pulse", int'(done), 0);

        // R9 good UDP, odd UDP, zero checksum skip, corrupted payloads
        mk_pkt(5, 17, 20, 64);
        run("R9 good udp", tl, 0, 0);
        mk_pkt(5, 17, 13, 64);
        run("R9 odd udp", tl, 0, 0);
        mk_pkt(5, 17, 20, 64);
        put16(hl + 6, 0);
        pkt[hl+10] ^= 8'h01;
        run("R9 udp zero sum skip", tl, 0, 0);
        mk_pkt(5, 17, 20, 64);
        pkt[hl+10] ^= 8'h01;
        run("R9 udp bad sum", tl, 0, 2);
        mk_pkt(5, 6, 29, 64);
        pkt[hl+25] ^= 8'h01;
        run("R9 tcp bad sum", tl, 0, 2);

        // R3 not IPv4
        mk_pkt(5, 6, 28, 64);
        pkt[0] = 8'h65;
        run("R3 version 6", tl, 1, 0);
        mk_pkt(5, 6, 28, 64);
        pkt[0] = 8'h44;
        run("R3 ihl 4", tl, 1, 0);

        // R4 header checksum, R7 transport silenced
        mk_pkt(5, 6, 28, 64);
        put16(hl, 0);
        fix_l4();
        pkt[11] ^= 8'h01;
        run("R4 R7 bad header sum", tl, 2, 0);

        // R5 truncation sweep
        mk_pkt(5, 6, 20, 64);
        for (int n = 1; n < 40; n++)
            run("R5 truncated", n, (n < 20) ? 3 : 4, 0);
        mk_pkt(5, 6, 20, 64);
        put16(2, 16);
        fix_ip();
        run("R5 total below header", 40, 3, 0);
        mk_pkt(5, 6, 28, 64);
        run("R5 trailing bytes", tl + 6, 0, 0);

        // R6 TTL sweep, options, ranking
        for (int t = 0; t < 8; t++) begin
            mk_pkt(5, 6, 28, t);
            run("R6 ttl sweep", tl, (t == 0) ? 5 : 0, 0);
        end
        mk_pkt(6, 17, 12, 64);
        run("R6 options", tl, 6, 0);
        mk_pkt(7, 6, 24, 0);
        run("R6 ttl before options", tl, 5, 0);

        // R7 transport still checked with codes 5, skipped for other protocols
        mk_pkt(5, 6, 28, 0);
        put16(hl, 0);
        fix_l4();
        run("R7 ttl0 port0", tl, 5, 4);
        // R2 stray bytes ignored, codes held
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) chk("R2 stray no pulse", int'(done), 0);
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 3); in_byte = 8'h45;
        end
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        chk("R2 stray no pulse", int'(done), 0);
        chk("R2 stray ip held", int'(ip_code), 5);
        chk("R2 stray l4 held", int'(l4_code), 4);

        mk_pkt(5, 1, 8, 64);
        run("R7 icmp", tl, 0, 0);

        // R8 malformed transport headers
        mk_pkt(5, 6, 16, 64);
        run("R8 tcp short", tl, 0, 1);
        mk_pkt(5, 17, 6, 64);
        run("R8 udp short", tl, 0, 1);
        mk_pkt(5, 6, 28, 64);
        pkt[hl+12] = 8'h40;
        fix_l4();
        run("R8 doff 4", tl, 0, 1);
        mk_pkt(5, 6, 28, 64);
        pkt[hl+12] = 8'h80;
        fix_l4();
        run("R8 doff beyond", tl, 0, 1);
        mk_pkt(5, 6, 28, 64);
        pkt[hl+12] = 8'h70;
        fix_l4();
        run("R8 doff at limit", tl, 0, 0);

        // R10 UDP length mismatch
        mk_pkt(5, 17, 20, 64);
        put16(hl + 4, 22);
        fix_l4();
        run("R10 ulen long", tl, 0, 3);
        mk_pkt(5, 17, 20, 64);
        put16(hl + 4, 19);
        fix_l4();
        run("R10 ulen short", tl, 0, 3);

        // R11 zero ports
        mk_pkt(5, 6, 28, 64);
        put16(hl, 0);
        fix_l4();
        run("R11 sport zero", tl, 0, 4);
        mk_pkt(5, 17, 20, 64);
        put16(hl + 2, 0);
        fix_l4();
        run("R11 dport zero", tl, 0, 4);

        // R12 full flag byte sweep
        for (int f = 0; f < 256; f++) begin
            mk_pkt(5, 6, 20, 64);
            pkt[hl+13] = 8'(f);
            fix_l4();
            run("R12 flags", tl, 0, flag_exp(f));
        end

        // R13 ranking among transport errors
        mk_pkt(5, 6, 16, 64);
        pkt[hl+10] ^= 8'h01;
        put16(hl, 0);
        run("R13 short over sum", tl, 0, 1);
        mk_pkt(5, 6, 28, 64);
        put16(hl, 0);
        run("R13 sum over port", tl, 0, 2);
        mk_pkt(5, 17, 20, 64);
        put16(hl + 4, 24);
        put16(hl + 2, 0);
        fix_l4();
        run("R13 len over port", tl, 0, 3);
        mk_pkt(5, 6, 28, 64);
        put16(hl, 0);
        pkt[hl+13] = 8'h00;
        fix_l4();
        run("R13 port over flags", tl, 0, 4);

        summary();
        $finish;
    end

endmodule